// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker turns a 32-bit virtual address into a physical address by reading first-level and, when needed, second-level descriptors from memory. Before it starts, it adds a process-ID offset to low addresses. It then checks the domain access control field for the descriptor's domain and, for client domains, the two-bit access permission of the mapping. The result is the physical address and the read/write rights of the requester. On a fault it returns an eight-bit status that packs the fault code with the domain number.

Each lookup is taken on a request handshake. Descriptors are fetched one word at a time over a request/response memory port, with at most one read outstanding. Each answer is a one-cycle result pulse. The configuration inputs (table base, domain register, offset, enable, system and ROM protection bits) are expected to stay steady while a walk is in flight. Sections, coarse and fine second-level tables are supported, with 64 KB, 4 KB and 1 KB pages.

Top module: `wk_walker`

## Requirements
- R1: After reset, out_valid and mem_req_valid are low and in_ready is high.
- R2: With cfg_walk_en low, an accepted lookup issues no memory read. The result appears on the cycle after acceptance, with out_paddr equal to the offset-adjusted address, both rights set, out_fault low and out_status zero.
- R3: cfg_pid_offset is added (modulo 2^32) to the virtual address only when that address is below PID_WINDOW (default 0x0200_0000). The sum is what gets translated.
- R4: The first read goes to {cfg_table_base[31:14], va[31:20], 2'b00}. A request holds valid and address steady until it is accepted. Only one read is outstanding, and no read is requested while the walker is idle.
- R5: First-level type is desc[1:0]. 0 is a fault with code 5, 2 is a section, 1 points to a coarse table and 3 points to a fine table. A section yields {desc[31:20], va[19:0]} and takes its permission from desc[11:10].
- R6: The domain is desc[8:5], and its field is cfg_domain_acc[2*dom+1:2*dom]. A field of 0 or 2 faults with code 9 for a section and 11 for a page descriptor, before any second read. A fault status is {dom, code[3:0]}, and a type-0 first-level fault also reports desc[8:5].
- R7: The second read goes to {desc[31:10], va[19:12], 2'b00} for a coarse table, or to {desc[31:12], va[19:10], 2'b00} for a fine table.
- R8: Second-level type is desc[1:0]. 0 faults with code 7. 1 is a 64 KB page {desc[31:16], va[15:0]} with permission desc[4+2*va[15:14] +: 2]. 2 is a 4 KB page {desc[31:12], va[11:0]} with permission desc[4+2*va[11:10] +: 2]. 3 is a 1 KB page {desc[31:10], va[9:0]} with permission desc[5:4].
- R9: A domain field of 3 grants read and write without any permission check.
- R10: For client domains (field 1), the grant {rd,wr} is as follows:
  - ap=3 gives 11.
  - ap=2 gives 11 privileged. For a user it gives 10 on a read and 00 on a write.
  - ap=1 gives 11 privileged and 00 for a user.
  - ap=0 gives 00 on a write. On a read it gives 10 when the ROM bit alone is set. When the system bit alone is set, it gives 10 for privileged and 00 for user. Otherwise it gives 00.
  - A grant of 00 is a permission fault, with code 13 for a section and 15 for a page.
- R11: out_valid is a one-cycle pulse. On a fault, out_paddr, out_rd_ok and out_wr_ok are zero. On success, out_status is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Lookup request |
| in_ready | output | 1 | Walker idle, request accepted |
| in_vaddr | input | 32 | Virtual address |
| in_user | input | 1 | Requester is unprivileged |
| in_write | input | 1 | Access is a write |
| cfg_walk_en | input | 1 | Translation enable |
| cfg_sys_prot | input | 1 | System protection bit for ap=0 |
| cfg_rom_prot | input | 1 | ROM protection bit for ap=0 |
| cfg_table_base | input | 32 | First-level table base (bits 31:14 used) |
| cfg_domain_acc | input | 32 | Two-bit access field per domain |
| cfg_pid_offset | input | 32 | Offset added to low addresses |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| out_valid | output | 1 | Result pulse |
| out_paddr | output | 32 | Physical address |
| out_rd_ok | output | 1 | Read granted |
| out_wr_ok | output | 1 | Write granted |
| out_fault | output | 1 | Lookup faulted |
| out_status | output | 8 | {domain, fault code} |

## Verification
The hardest situations to reach are those that depend on several independent fields lining up. Examples are a page whose subpage index selects one particular permission pair, a permission-0 mapping evaluated under each setting of the two protection bits, and a low address whose offset moves it onto a prepared descriptor. Directed walks place hand-built descriptors at the exact addresses the bench computes, and sweep the permission value, protection bits, privilege and direction exhaustively on a section. Randomised walks then write random descriptors at the computed first- and second-level addresses, under random domain registers and a back-pressured memory with variable latency.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } wk_state_e;

  typedef enum logic [1:0] {
    L1_FAULT = 2'd0, L1_COARSE = 2'd1, L1_SECTION = 2'd2, L1_FINE = 2'd3
  } wk_l1_kind_e;

  localparam logic [3:0] FC_SEC_XLT  = 4'd5;
  localparam logic [3:0] FC_PAGE_XLT = 4'd7;
  localparam logic [3:0] FC_SEC_DOM  = 4'd9;
  localparam logic [3:0] FC_PAGE_DOM = 4'd11;
  localparam logic [3:0] FC_SEC_AP   = 4'd13;
  localparam logic [3:0] FC_PAGE_AP  = 4'd15;

  // Client-domain grant {rd,wr} for one access.
  function automatic logic [1:0] wk_grant(input logic [1:0] ap, input logic sys_p,
                                          input logic rom_p, input logic user,
                                          input logic write);
    logic [1:0] g;
    unique case (ap)
      2'd0: begin
        if (write)                g = 2'b00;
        else if (sys_p && !rom_p) g = user ? 2'b00 : 2'b10;
        else if (rom_p && !sys_p) g = 2'b10;
        else                      g = 2'b00;
      end
      2'd1:    g = user ? 2'b00 : 2'b11;
      2'd2:    g = !user ? 2'b11 : (write ? 2'b00 : 2'b10);
      default: g = 2'b11;
    endcase
    return g;
  endfunction

  function automatic logic [31:0] wk_l1_addr(input logic [17:0] base_hi,
                                             input logic [11:0] va_hi);
    return {base_hi, va_hi, 2'b00};
  endfunction

endpackage

// File: rtl/wk_perm.sv
module wk_perm
  import wk_pkg::*;
(
  input  logic [1:0] ap,
  input  logic [1:0] dom_field,
  input  logic       sys_p,
  input  logic       rom_p,
  input  logic       user,
  input  logic       write,
  output logic [1:0] grant,
  output logic       deny
);
  assign grant = (dom_field == 2'b11) ? 2'b11 : wk_grant(ap, sys_p, rom_p, user, write);
  assign deny  = (grant == 2'b00);
endmodule

// File: rtl/wk_l1_decode.sv
module wk_l1_decode
  import wk_pkg::*;
#(
  parameter int DOM_W = 4
) (
  input  logic [31:0]          desc,
  input  logic [19:0]          va_lo,
  input  logic [(2<<DOM_W)-1:0] dom_acc,
  output wk_l1_kind_e          kind,
  output logic [DOM_W-1:0]     dom_num,
  output logic [1:0]           dom_field,
  output logic [31:0]          sec_paddr,
  output logic [1:0]           sec_ap,
  output logic [31:0]          l2_addr
);
  logic unused_l1;
  assign unused_l1 = ^{desc[9], desc[4:2]};

  assign kind      = wk_l1_kind_e'(desc[1:0]);
  assign dom_num   = desc[5 +: DOM_W];
  assign dom_field = dom_acc[{dom_num, 1'b0} +: 2];
  assign sec_paddr = {desc[31:20], va_lo};
  assign sec_ap    = desc[11:10];
  assign l2_addr   = (kind == L1_FINE) ? {desc[31:12], va_lo[19:10], 2'b00}
                                       : {desc[31:10], va_lo[19:12], 2'b00};
endmodule

// File: rtl/wk_l2_decode.sv
module wk_l2_decode (
  input  logic [31:0] desc,
  input  logic [15:0] va_lo,
  output logic        is_fault,
  output logic [31:0] paddr,
  output logic [1:0]  ap
);
  logic       unused_l2;
  logic [3:0] sub_idx;
  assign unused_l2 = ^desc[3:2];
  assign is_fault  = (desc[1:0] == 2'd0);

  always_comb begin
    sub_idx = 4'd0;
    paddr   = 32'h0;
    unique case (desc[1:0])
      2'd1: begin
        paddr   = {desc[31:16], va_lo[15:0]};
        sub_idx = {1'b0, va_lo[15:14], 1'b0};
      end
      2'd2: begin
        paddr   = {desc[31:12], va_lo[11:0]};
        sub_idx = {1'b0, va_lo[11:10], 1'b0};
      end
      2'd3: paddr = {desc[31:10], va_lo[9:0]};
      default: paddr = 32'h0;
    endcase
  end

  assign ap = desc[4'd4 + sub_idx +: 2];
endmodule

// File: rtl/wk_walker.sv
module wk_walker
  import wk_pkg::*;
#(
  parameter logic [31:0] PID_WINDOW = 32'h0200_0000,
  parameter int          DOM_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [31:0]          in_vaddr,
  input  logic                 in_user,
  input  logic                 in_write,
  input  logic                 cfg_walk_en,
  input  logic                 cfg_sys_prot,
  input  logic                 cfg_rom_prot,
  input  logic [31:0]          cfg_table_base,
  input  logic [(2<<DOM_W)-1:0] cfg_domain_acc,
  input  logic [31:0]          cfg_pid_offset,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [31:0]          mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [31:0]          mem_rsp_data,
  output logic                 out_valid,
  output logic [31:0]          out_paddr,
  output logic                 out_rd_ok,
  output logic                 out_wr_ok,
  output logic                 out_fault,
  output logic [DOM_W+3:0]     out_status
);
  localparam int ST_W = DOM_W + 4;

  wk_state_e        state;
  logic [31:0]      va_q, l2_addr_q, res_paddr_q;
  logic             user_q, write_q, res_fault_q;
  logic [DOM_W-1:0] dom_q;
  logic [1:0]       domf_q, res_grant_q;
  logic [ST_W-1:0]  res_status_q;
  logic             unused_top;
  assign unused_top = ^cfg_table_base[13:0];

  // Offset-adjusted address.
  logic [31:0] va_eff;
  assign va_eff = (in_vaddr < PID_WINDOW) ? in_vaddr + cfg_pid_offset : in_vaddr;

  // Descriptor decoders.
  wk_l1_kind_e      l1_kind;
  logic [DOM_W-1:0] l1_dom;
  logic [1:0]       l1_domf, l1_ap, l2_ap, perm_grant;
  logic [31:0]      l1_paddr, l1_l2addr, l2_paddr;
  logic             l2_fault, perm_deny;

  wk_l1_decode #(.DOM_W(DOM_W)) u_l1 (
    .desc(mem_rsp_data), .va_lo(va_q[19:0]), .dom_acc(cfg_domain_acc),
    .kind(l1_kind), .dom_num(l1_dom), .dom_field(l1_domf),
    .sec_paddr(l1_paddr), .sec_ap(l1_ap), .l2_addr(l1_l2addr));

  wk_l2_decode u_l2 (
    .desc(mem_rsp_data), .va_lo(va_q[15:0]),
    .is_fault(l2_fault), .paddr(l2_paddr), .ap(l2_ap));

  wk_perm u_perm (
    .ap(state == ST_L1_WAIT ? l1_ap : l2_ap),
    .dom_field(state == ST_L1_WAIT ? l1_domf : domf_q),
    .sys_p(cfg_sys_prot), .rom_p(cfg_rom_prot), .user(user_q), .write(write_q),
    .grant(perm_grant), .deny(perm_deny));

  // Named walk events.
  logic             fin_now, fin_fault, go_l2, l1_phase;
  logic [3:0]       fin_code;
  logic [31:0]      fin_paddr;
  logic [DOM_W-1:0] fin_dom;

  always_comb begin
    fin_now   = 1'b0;
    fin_fault = 1'b0;
    fin_code  = 4'd0;
    fin_paddr = 32'h0;
    fin_dom   = dom_q;
    go_l2     = 1'b0;
    if (state == ST_L1_WAIT && mem_rsp_valid) begin
      fin_dom = l1_dom;
      fin_now = 1'b1;
      if (l1_kind == L1_FAULT) begin
        fin_fault = 1'b1;
        fin_code  = FC_SEC_XLT;
      end else if (!l1_domf[0]) begin
        fin_fault = 1'b1;
        fin_code  = (l1_kind == L1_SECTION) ? FC_SEC_DOM : FC_PAGE_DOM;
      end else if (l1_kind == L1_SECTION) begin
        fin_fault = perm_deny;
        fin_code  = FC_SEC_AP;
        fin_paddr = l1_paddr;
      end else begin
        fin_now = 1'b0;
        go_l2   = 1'b1;
      end
    end else if (state == ST_L2_WAIT && mem_rsp_valid) begin
      fin_now   = 1'b1;
      fin_fault = l2_fault | perm_deny;
      fin_code  = l2_fault ? FC_PAGE_XLT : FC_PAGE_AP;
      fin_paddr = l2_paddr;
    end
  end

  assign l1_phase      = (state == ST_L1_REQ);
  assign in_ready      = (state == ST_IDLE);
  assign mem_req_valid = l1_phase || (state == ST_L2_REQ);
  assign mem_req_addr  = l1_phase ? wk_l1_addr(cfg_table_base[31:14], va_q[31:20]) : l2_addr_q;
  assign out_valid     = (state == ST_DONE);
  assign out_paddr     = res_paddr_q;
  assign out_rd_ok     = res_grant_q[1];
  assign out_wr_ok     = res_grant_q[0];
  assign out_fault     = res_fault_q;
  assign out_status    = res_status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      va_q         <= 32'h0;
      l2_addr_q    <= 32'h0;
      user_q       <= 1'b0;
      write_q      <= 1'b0;
      dom_q        <= '0;
      domf_q       <= 2'b00;
      res_paddr_q  <= 32'h0;
      res_grant_q  <= 2'b00;
      res_fault_q  <= 1'b0;
      res_status_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          va_q    <= va_eff;
          user_q  <= in_user;
          write_q <= in_write;
          if (cfg_walk_en) begin
            state <= ST_L1_REQ;
          end else begin
            res_paddr_q  <= va_eff;
            res_grant_q  <= 2'b11;
            res_fault_q  <= 1'b0;
            res_status_q <= '0;
            state        <= ST_DONE;
          end
        end
        ST_L1_REQ: if (mem_req_ready) state <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          dom_q     <= l1_dom;
          domf_q    <= l1_domf;
          l2_addr_q <= l1_l2addr;
          state     <= go_l2 ? ST_L2_REQ : ST_DONE;
        end
        ST_L2_REQ:  if (mem_req_ready) state <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) state <= ST_DONE;
        default:    state <= ST_IDLE;
      endcase
      if (fin_now) begin
        res_fault_q  <= fin_fault;
        res_paddr_q  <= fin_fault ? 32'h0 : fin_paddr;
        res_grant_q  <= fin_fault ? 2'b00 : perm_grant;
        res_status_q <= fin_fault ? {fin_dom, fin_code} : '0;
      end
    end
  end
endmodule

// File: rtl/wk_walker_chk.sv
module wk_walker_chk #(
  parameter int DOM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              cfg_walk_en,
  input logic [31:0]       cfg_table_base,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [31:0]       mem_req_addr,
  input logic              out_valid,
  input logic [31:0]       out_paddr,
  input logic              out_rd_ok,
  input logic              out_wr_ok,
  input logic              out_fault,
  input logic [DOM_W+3:0]  out_status,
  input logic              l1_phase,
  input logic              fin_now
);
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req_valid); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4
  AST_L1_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    l1_phase && mem_req_valid |-> mem_req_addr[31:14] == cfg_table_base[31:14] && mem_req_addr[1:0] == 2'b00); // R4
  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !cfg_walk_en |=> out_valid && out_rd_ok && out_wr_ok && !out_fault); // R2
  AST_FAULT_CODE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> out_status[0] && out_status[3:0] >= 4'd5); // R6
  AST_WRITE_IMPLIES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wr_ok |-> out_rd_ok); // R10
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R11
  AST_FINISH_TO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    fin_now |=> out_valid); // R11
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fault |-> !out_rd_ok && !out_wr_ok && out_paddr == 32'h0); // R11
endmodule

bind wk_walker wk_walker_chk #(.DOM_W(DOM_W)) u_wk_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cfg_walk_en(cfg_walk_en), .cfg_table_base(cfg_table_base),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .out_valid(out_valid), .out_paddr(out_paddr),
  .out_rd_ok(out_rd_ok), .out_wr_ok(out_wr_ok), .out_fault(out_fault),
  .out_status(out_status), .l1_phase(l1_phase), .fin_now(fin_now));

// File: tb/wk_walker_bench.sv
`timescale 1ns/1ps
module wk_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_user = 1'b0, in_write = 1'b0;
  logic [31:0] in_vaddr = 32'h0;
  logic        cfg_walk_en = 1'b1, cfg_sys_prot = 1'b0, cfg_rom_prot = 1'b0;
  logic [31:0] cfg_table_base = 32'h0004_0000, cfg_domain_acc = 32'h0, cfg_pid_offset = 32'h0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'h0;
  logic        in_ready, mem_req_valid, out_valid, out_rd_ok, out_wr_ok, out_fault;
  logic [31:0] mem_req_addr, out_paddr;
  logic [7:0]  out_status;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wk_walker u_wk_walker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vaddr(in_vaddr), .in_user(in_user), .in_write(in_write),
    .cfg_walk_en(cfg_walk_en), .cfg_sys_prot(cfg_sys_prot), .cfg_rom_prot(cfg_rom_prot),
    .cfg_table_base(cfg_table_base), .cfg_domain_acc(cfg_domain_acc),
    .cfg_pid_offset(cfg_pid_offset), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_paddr(out_paddr), .out_rd_ok(out_rd_ok),
    .out_wr_ok(out_wr_ok), .out_fault(out_fault), .out_status(out_status));

  // ---------------- memory model ----------------
  logic [31:0] tmem [logic [31:0]];
  logic [31:0] seen [0:3];
  int          nseen = 0;
  logic        hs = 1'b0;
  logic [31:0] hs_addr = 32'h0;
  logic        pend = 1'b0;
  int          dly = 0;

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    if (tmem.exists(a)) return tmem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    hs <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      hs_addr <= mem_req_addr;
      if (nseen < 4) seen[nseen] <= mem_req_addr;
      nseen <= nseen + 1;
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (hs) begin
      pend = 1'b1;
      dly  = $urandom_range(0, 2);
    end
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd_mem(hs_addr);
        pend = 1'b0;
      end else dly = dly - 1;
    end
    mem_req_ready = ($urandom_range(0, 3) != 0);
  end

  // ---------------- reference model ----------------
  logic [31:0] exp_a1, exp_a2;
  bit          exp_two;

  function automatic logic [31:0] eff_va(input logic [31:0] va);
    return (va < 32'h0200_0000) ? va + cfg_pid_offset : va;
  endfunction

  function automatic logic [31:0] l1_of(input logic [31:0] va);
    return (cfg_table_base & 32'hFFFF_C000) | ((eff_va(va) >> 18) & 32'h3FFC);
  endfunction

  function automatic logic [31:0] l2_of(input logic [31:0] d1, input logic [31:0] va);
    logic [31:0] v;
    v = eff_va(va);
    if (d1[1:0] == 2'd1) return (d1 & 32'hFFFF_FC00) | ((v >> 10) & 32'h3FC);
    return (d1 & 32'hFFFF_F000) | ((v >> 8) & 32'hFFC);
  endfunction

  function automatic logic [1:0] bench_ap(input logic [1:0] ap, input bit user, input bit wr);
    if (ap == 2'd3) return 2'b11;
    if (ap == 2'd2) begin
      if (!user) return 2'b11;
      return wr ? 2'b00 : 2'b10;
    end
    if (ap == 2'd1) return user ? 2'b00 : 2'b11;
    if (wr) return 2'b00;
    if (cfg_rom_prot && !cfg_sys_prot) return 2'b10;
    if (cfg_sys_prot && !cfg_rom_prot && !user) return 2'b10;
    return 2'b00;
  endfunction

  // Result layout: {paddr[31:0], rd, wr, fault, status[7:0]}.
  function automatic logic [42:0] ref_walk(input logic [31:0] va_in, input bit user, input bit wr);
    logic [31:0] va, d1, d2, pa;
    logic [3:0]  dom, code;
    logic [1:0]  df, ap, g;
    int          sh;
    va = eff_va(va_in);
    exp_two = 1'b0;
    exp_a1 = l1_of(va_in);
    exp_a2 = 32'h0;
    if (!cfg_walk_en) return {va, 1'b1, 1'b1, 1'b0, 8'h00};
    d1  = rd_mem(exp_a1);
    dom = 4'((d1 >> 5) & 32'hF);
    df  = 2'((cfg_domain_acc >> (2 * dom)) & 32'h3);
    if (d1[1:0] == 2'd0) return {32'h0, 2'b00, 1'b1, dom, 4'd5};
    if (df == 2'd0 || df == 2'd2)
      return {32'h0, 2'b00, 1'b1, dom, (d1[1:0] == 2'd2) ? 4'd9 : 4'd11};
    if (d1[1:0] == 2'd2) begin
      pa   = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
      ap   = 2'((d1 >> 10) & 32'h3);
      code = 4'd13;
    end else begin
      exp_two = 1'b1;
      exp_a2  = l2_of(d1, va_in);
      d2 = rd_mem(exp_a2);
      code = 4'd15;
      case (d2[1:0])
        2'd0: return {32'h0, 2'b00, 1'b1, dom, 4'd7};
        2'd1: begin
          pa = (d2 & 32'hFFFF_0000) | (va & 32'hFFFF);
          sh = 4 + 2 * int'((va >> 14) & 32'h3);
          ap = 2'((d2 >> sh) & 32'h3);
        end
        2'd2: begin
          pa = (d2 & 32'hFFFF_F000) | (va & 32'hFFF);
          sh = 4 + 2 * int'((va >> 10) & 32'h3);
          ap = 2'((d2 >> sh) & 32'h3);
        end
        default: begin
          pa = (d2 & 32'hFFFF_FC00) | (va & 32'h3FF);
          ap = 2'((d2 >> 4) & 32'h3);
        end
      endcase
    end
    if (df == 2'd3) return {pa, 2'b11, 1'b0, 8'h00};
    g = bench_ap(ap, user, wr);
    if (g == 2'b00) return {32'h0, 2'b00, 1'b1, dom, code};
    return {pa, g, 1'b0, 8'h00};
  endfunction

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_walk(input logic [31:0] va, input bit user, input bit wr, input string tag);
    logic [42:0] exp, act;
    int          waited;
    exp = ref_walk(va, user, wr);
    while (!in_ready) @(negedge clk);
    nseen    = 0;
    in_valid = 1'b1;
    in_vaddr = va;
    in_user  = user;
    in_write = wr;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    waited = 0;
    while (!out_valid && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    act = {out_paddr, out_rd_ok, out_wr_ok, out_fault, out_status};
    check(act == exp, tag, 64'(act), 64'(exp));
    if (!cfg_walk_en) begin
      check(waited == 0 && nseen == 0, "R2 bypass latency/reads", 64'(waited), 64'd0);
    end else begin
      check(seen[0] == exp_a1, "R4 first-level address", 64'(seen[0]), 64'(exp_a1));
      if (exp_two)
        check(nseen == 2 && seen[1] == exp_a2, "R7 second-level address", 64'(seen[1]), 64'(exp_a2));
      else
        check(nseen == 1, "R6 no second read", 64'(nseen), 64'd1);
    end
    @(negedge clk);
    check(!out_valid, "R11 one-cycle result", 64'(out_valid), 64'd0);
  endtask

  task automatic put_l1(input logic [31:0] va, input logic [31:0] d1);
    tmem[l1_of(va)] = d1;
  endtask

  task automatic put_page(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2);
    tmem[l1_of(va)] = d1;
    tmem[l2_of(d1, va)] = d2;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!out_valid && !mem_req_valid && in_ready, "R1 reset state",
          64'({out_valid, mem_req_valid, in_ready}), 64'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !mem_req_valid && in_ready, "R1 after release",
          64'({out_valid, mem_req_valid, in_ready}), 64'b001);

    // Domains: 1 client, 2 manager, 3 field 0, 4 field 2.
    cfg_domain_acc = 32'h0000_0234;

    do_walk(32'h1230_0000, 1'b0, 1'b0, "R5 first-level fault");
    put_l1(32'h4560_1234, 32'h8AB0_0C22);
    do_walk(32'h4560_1234, 1'b1, 1'b1, "R5 section map");
    put_l1(32'h4570_0000, 32'h8AB0_0C62);
    do_walk(32'h4570_0000, 1'b0, 1'b0, "R6 section domain fault");
    put_l1(32'h4580_0000, 32'h0010_0081);
    do_walk(32'h4580_0000, 1'b0, 1'b0, "R6 page domain fault");
    put_l1(32'h4588_0000, 32'h9000_0042);
    do_walk(32'h4588_0000, 1'b1, 1'b1, "R9 manager bypass");

    // Permission sweep on a client section.
    for (int p = 0; p < 4; p++) begin
      cfg_sys_prot = p[0];
      cfg_rom_prot = p[1];
      for (int ap = 0; ap < 4; ap++) begin
        put_l1(32'h4590_0000, 32'h9100_0022 | (32'(ap) << 10));
        for (int k = 0; k < 4; k++)
          do_walk(32'h4590_0ABC, k[0], k[1], "R10 permission table");
      end
    end
    cfg_sys_prot = 1'b0;
    cfg_rom_prot = 1'b0;

    // Coarse table, 64 KB page, subpage permissions 0,1,2,3.
    put_page(32'h45A3_C567, 32'h0012_3421, 32'h7777_0000 | (32'hE4 << 4) | 32'd1);
    do_walk(32'h45A3_C567, 1'b1, 1'b1, "R8 64K subpage 3");
    do_walk(32'h45A3_4567, 1'b1, 1'b0, "R8 64K subpage 1");
    // 4 KB page, subpage chosen by va[11:10].
    put_page(32'h45B0_0800, 32'h0012_3821, 32'h6666_6000 | (32'hE4 << 4) | 32'd2);
    do_walk(32'h45B0_0800, 1'b1, 1'b1, "R8 4K subpage 2 user write");
    do_walk(32'h45B0_0800, 1'b0, 1'b1, "R8 4K subpage 2 privileged");
    // Fine table, 1 KB page.
    put_page(32'h45C1_23F0, 32'h0013_5023, 32'h5555_5400 | (32'd3 << 4) | 32'd3);
    do_walk(32'h45C1_23F0, 1'b1, 1'b1, "R8 1K page");
    // Second-level fault.
    put_page(32'h45D0_0000, 32'h0014_0021, 32'h0);
    do_walk(32'h45D0_0000, 1'b0, 1'b0, "R8 second-level fault");

    // Offset window and bypass.
    cfg_pid_offset = 32'h4500_0000;
    put_l1(32'h0010_0000, 32'hA000_0C22);
    do_walk(32'h0010_0000, 1'b0, 1'b0, "R3 offset applied before walk");
    cfg_walk_en = 1'b0;
    cfg_pid_offset = 32'h0600_0000;
    do_walk(32'h01FF_FFFC, 1'b0, 1'b1, "R3 last offset address");
    do_walk(32'h0200_0000, 1'b1, 1'b0, "R3 first address past window");
    do_walk(32'hDEAD_BEE0, 1'b1, 1'b1, "R2 bypass high address");
    cfg_walk_en = 1'b1;

    // Randomised walks.
    for (int n = 0; n < 400; n++) begin
      logic [31:0] va, d1;
      cfg_walk_en    = ($urandom_range(0, 7) != 0);
      cfg_sys_prot   = 1'($urandom);
      cfg_rom_prot   = 1'($urandom);
      cfg_table_base = $urandom;
      cfg_domain_acc = $urandom;
      cfg_pid_offset = $urandom;
      va = ($urandom_range(0, 2) == 0) ? ($urandom & 32'h01FF_FFFF) : $urandom;
      d1 = $urandom;
      if (d1[1:0] == 2'd2 || d1[1:0] == 2'd0) put_l1(va, d1);
      else put_page(va, d1, $urandom);
      do_walk(va, 1'($urandom), 1'($urandom), "R10 random walk");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule